// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two low-power states of a small 8-bit microcontroller core: a light sleep state (idle) and a deep sleep state (power-down). Software requests a state by writing a power control register. The block then turns that request into clock enables for the CPU, the watchdog and the other peripherals. It also produces the override selects that force the external bus strobes and the port output multiplexers into the pin state required for the chosen state.

In idle the oscillator keeps running. Only the CPU clock enable, the CPU register write enable and the watchdog clock enable drop. The interrupt logic, the serial unit, the USB unit and the remaining timers keep their clocks, and the port inputs stay sampled, so an enabled interrupt can bring the core back. In power-down every enable drops, and only reset returns the core to normal operation. Entry to power-down is guarded by an arming write. The pin state forced on ports 0 and 2 depends on whether the last opcode fetch came from internal or external code memory. That origin is captured when a low-power state is entered.

Top module: `lpm_ctrl`

## Requirements
- R1: After synchronous reset `mode_o` is 0 (run), `cpu_clk_en`, `cpu_wr_en`, `wdt_clk_en`, `port_in_en` are 1, every bit of `per_clk_en` is 1, `bus_ovr` is 0 and `p0_sel`, `p2_sel`, `p13_sel` are 0 (normal). Reset also returns power-down or idle to run.
- R2: In run, a register write with bit 0 set (and no valid power-down request) enters idle (`mode_o`=1) at the next clock edge. In idle, `cpu_clk_en`, `cpu_wr_en` and `wdt_clk_en` are 0, while `per_clk_en` stays all ones and `port_in_en` stays 1.
- R3: In idle, `irq_pend`=1 returns the block to run at the next edge, and the idle request is cleared. In run, `irq_pend` has no effect.
- R4: A write with bit 1 set enters power-down (`mode_o`=2) only when the immediately preceding register write had bit 7 set. Any other write in between disarms it. A single write with bits 7 and 1 both set does not enter power-down, but it does arm the next write. Power-down takes priority over idle in the same write.
- R5: In power-down, `cpu_clk_en`, `cpu_wr_en`, `wdt_clk_en`, `port_in_en` and all of `per_clk_en` are 0. `irq_pend` is ignored, and only reset leaves the state.
- R6: `bus_ovr` is 0 in run and 1 in both low-power states. `bus_lvl` is 1 in idle (strobes held high) and 0 in power-down (strobes held low).
- R7: With an internal last fetch, `p0_sel` and `p2_sel` are 1 (drive latch data) in both idle and power-down.
- R8: With an external last fetch, `p0_sel` is 3 (float) in both low-power states, and `p2_sel` is 2 (address high byte) in idle and 1 (latch data) in power-down.
- R9: `p13_sel` is 0 (latch data or active alternate output continues) in idle and 1 (hold last output) in power-down.
- R10: The fetch-origin flag follows `fetch_ext` on each cycle with `fetch_valid`=1 in run. A fetch in the same cycle as the entering write counts. Fetches reported while idle or in power-down are ignored, and the flag is frozen until the next entry.
- R11: Register writes made while idle or in power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe of the power control register |
| reg_wdata | input | 8 | Write data: bit 0 idle, bit 1 power-down, bit 7 arm |
| irq_pend | input | 1 | An enabled interrupt request is pending |
| fetch_valid | input | 1 | An opcode fetch happens this cycle |
| fetch_ext | input | 1 | The fetch comes from external code memory |
| mode_o | output | 2 | State: 0 run, 1 idle, 2 power-down |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_wr_en | output | 1 | CPU register write enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| per_clk_en | output | NUM_PER | Clock enables of interrupt, serial, USB and timer units |
| port_in_en | output | 1 | Port input sampling enable |
| bus_ovr | output | 1 | Override of the bus strobes is active |
| bus_lvl | output | 1 | Forced strobe level when overridden |
| p0_sel | output | 2 | Port 0 output select: 0 normal, 1 latch, 2 address, 3 float |
| p2_sel | output | 2 | Port 2 output select, same encoding |
| p13_sel | output | 2 | Ports 1 and 3 select: 0 normal, 1 hold last output |

## Verification
The hardest cases to reach are those where the fetch-origin flag has to survive a round trip. One is a fetch reported while the CPU is asleep, which must not change the flag. Another is a fetch in the very cycle of the entering write, which must. The stimulus table reports an external fetch, enters idle, reports an internal fetch during idle, wakes, and re-enters with no fetch, so the port 0 and port 2 selects show the old origin. The arming rule needs a similar walk: an armed write followed by an unrelated write, a combined arm and power-down write, and a power-down write that carries a fetch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } lpm_mode_e;

  typedef enum logic [1:0] {
    PSEL_NORMAL = 2'd0,
    PSEL_LATCH  = 2'd1,
    PSEL_ADDR   = 2'd2,
    PSEL_FLOAT  = 2'd3
  } lpm_psel_e;
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int IDLE_BIT = 0,
  parameter int PD_BIT   = 1,
  parameter int ARM_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          irq_pend,
  input  logic          fetch_valid,
  input  logic          fetch_ext,
  output lpm_mode_e     mode_q,
  output lpm_mode_e     mode_d,
  output logic          ext_lat_d
);
  logic armed_q, armed_d;
  logic ext_last_q, ext_last_d;
  logic ext_lat_q;
  logic ext_now;
  logic req_idle, req_pd, req_arm;
  logic unused_wdata;

  assign req_idle     = reg_wdata[IDLE_BIT];
  assign req_pd       = reg_wdata[PD_BIT];
  assign req_arm      = reg_wdata[ARM_BIT];
  assign unused_wdata = ^reg_wdata;
  assign ext_now      = fetch_valid ? fetch_ext : ext_last_q;

  always_comb begin
    mode_d     = mode_q;
    armed_d    = armed_q;
    ext_last_d = ext_last_q;
    ext_lat_d  = ext_lat_q;
    case (mode_q)
      MODE_RUN: begin
        if (fetch_valid) ext_last_d = fetch_ext;
        if (reg_wr) begin
          armed_d = req_arm;
          if (req_pd && armed_q)  mode_d = MODE_PD;
          else if (req_idle)      mode_d = MODE_IDLE;
          if (mode_d != MODE_RUN) begin
            ext_lat_d = ext_now;
            armed_d   = 1'b0;
          end
        end
      end
      MODE_IDLE: begin
        if (irq_pend) mode_d = MODE_RUN;
      end
      MODE_PD: begin
        mode_d = MODE_PD;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RUN;
      armed_q    <= 1'b0;
      ext_last_q <= 1'b0;
      ext_lat_q  <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      armed_q    <= armed_d;
      ext_last_q <= ext_last_d;
      ext_lat_q  <= ext_lat_d;
    end
  end

  // R3: a pending interrupt always ends idle one cycle later
  a_r3_idle_wakes: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IDLE && irq_pend) |=> (mode_q == MODE_RUN));

  // R5: power-down is left only through reset
  a_r5_pd_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PD) |=> (mode_q == MODE_PD));

  // R4: power-down is only ever entered from a power-down write in run
  a_r4_pd_from_write: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PD && $past(mode_q) == MODE_RUN)
      |-> ($past(reg_wr) && $past(req_pd) && $past(armed_q)));

  // R10: the captured fetch origin is frozen while asleep
  a_r10_flag_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN) |=> $stable(ext_lat_q));

  // R11: writes during sleep never move to another sleep state
  a_r11_sleep_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IDLE && !irq_pend) |=> (mode_q == MODE_IDLE));
endmodule

// File: rtl/lpm_clk_en.sv
module lpm_clk_en
  import lpm_pkg::*;
#(
  parameter int              NUM_PER       = 4,
  parameter logic [NUM_PER-1:0] PER_IDLE_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  lpm_mode_e          mode_d,
  output logic               cpu_clk_en,
  output logic               cpu_wr_en,
  output logic               wdt_clk_en,
  output logic [NUM_PER-1:0] per_clk_en,
  output logic               port_in_en
);
  logic run_d, idle_d;

  assign run_d  = (mode_d == MODE_RUN);
  assign idle_d = (mode_d == MODE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      cpu_wr_en  <= 1'b1;
      wdt_clk_en <= 1'b1;
      port_in_en <= 1'b1;
    end else begin
      cpu_clk_en <= run_d;
      cpu_wr_en  <= run_d;
      wdt_clk_en <= run_d;
      port_in_en <= run_d | idle_d;
    end
  end

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    always_ff @(posedge clk) begin
      if (rst) per_clk_en[i] <= 1'b1;
      else     per_clk_en[i] <= run_d | (idle_d & PER_IDLE_MASK[i]);
    end
  end

  // R2: a stopped CPU clock never coincides with register writes
  a_r2_cpu_frozen: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |-> !cpu_wr_en);

  // R2: the watchdog never runs while the CPU is stopped
  a_r2_wdt_off: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_en |-> !wdt_clk_en);

  // R5: no peripheral clock once input sampling has stopped
  a_r5_all_off: assert property (@(posedge clk) disable iff (rst)
    !port_in_en |-> (per_clk_en == '0 && !cpu_clk_en));
endmodule

// File: rtl/lpm_pin_ovr.sv
module lpm_pin_ovr
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lpm_mode_e mode_d,
  input  logic      ext_lat_d,
  output logic      bus_ovr,
  output logic      bus_lvl,
  output lpm_psel_e p0_sel,
  output lpm_psel_e p2_sel,
  output lpm_psel_e p13_sel
);
  lpm_psel_e p0_nx, p2_nx, p13_nx;

  always_comb begin
    p0_nx  = PSEL_NORMAL;
    p2_nx  = PSEL_NORMAL;
    p13_nx = PSEL_NORMAL;
    case (mode_d)
      MODE_IDLE: begin
        p0_nx = ext_lat_d ? PSEL_FLOAT : PSEL_LATCH;
        p2_nx = ext_lat_d ? PSEL_ADDR  : PSEL_LATCH;
      end
      MODE_PD: begin
        p0_nx  = ext_lat_d ? PSEL_FLOAT : PSEL_LATCH;
        p2_nx  = PSEL_LATCH;
        p13_nx = PSEL_LATCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ovr <= 1'b0;
      bus_lvl <= 1'b0;
      p0_sel  <= PSEL_NORMAL;
      p2_sel  <= PSEL_NORMAL;
      p13_sel <= PSEL_NORMAL;
    end else begin
      bus_ovr <= (mode_d != MODE_RUN);
      bus_lvl <= (mode_d == MODE_IDLE);
      p0_sel  <= p0_nx;
      p2_sel  <= p2_nx;
      p13_sel <= p13_nx;
    end
  end

  // R6/R9: strobes held high only in idle, where ports 1/3 keep running
  a_r6_idle_pins: assert property (@(posedge clk) disable iff (rst)
    (bus_ovr && bus_lvl) |-> (p13_sel == PSEL_NORMAL));

  // R8: a floating port 0 implies port 2 is overridden too
  a_r8_float_pairs: assert property (@(posedge clk) disable iff (rst)
    (p0_sel == PSEL_FLOAT) |-> (p2_sel != PSEL_NORMAL));

  // R6: no pin override without strobe override
  a_r6_no_stray_ovr: assert property (@(posedge clk) disable iff (rst)
    !bus_ovr |-> (p0_sel == PSEL_NORMAL && p2_sel == PSEL_NORMAL));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int                 DW            = 8,
  parameter int                 NUM_PER       = 4,
  parameter int                 IDLE_BIT      = 0,
  parameter int                 PD_BIT        = 1,
  parameter int                 ARM_BIT       = 7,
  parameter logic [NUM_PER-1:0] PER_IDLE_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               irq_pend,
  input  logic               fetch_valid,
  input  logic               fetch_ext,
  output logic [1:0]         mode_o,
  output logic               cpu_clk_en,
  output logic               cpu_wr_en,
  output logic               wdt_clk_en,
  output logic [NUM_PER-1:0] per_clk_en,
  output logic               port_in_en,
  output logic               bus_ovr,
  output logic               bus_lvl,
  output logic [1:0]         p0_sel,
  output logic [1:0]         p2_sel,
  output logic [1:0]         p13_sel
);
  lpm_mode_e mode_q, mode_d;
  logic      ext_lat_d;
  lpm_psel_e p0_e, p2_e, p13_e;

  lpm_mode_fsm #(
    .DW(DW), .IDLE_BIT(IDLE_BIT), .PD_BIT(PD_BIT), .ARM_BIT(ARM_BIT)
  ) i_fsm (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .irq_pend(irq_pend), .fetch_valid(fetch_valid), .fetch_ext(fetch_ext),
    .mode_q(mode_q), .mode_d(mode_d), .ext_lat_d(ext_lat_d)
  );

  lpm_clk_en #(
    .NUM_PER(NUM_PER), .PER_IDLE_MASK(PER_IDLE_MASK)
  ) i_clk (
    .clk(clk), .rst(rst), .mode_d(mode_d),
    .cpu_clk_en(cpu_clk_en), .cpu_wr_en(cpu_wr_en), .wdt_clk_en(wdt_clk_en),
    .per_clk_en(per_clk_en), .port_in_en(port_in_en)
  );

  lpm_pin_ovr i_pin (
    .clk(clk), .rst(rst), .mode_d(mode_d), .ext_lat_d(ext_lat_d),
    .bus_ovr(bus_ovr), .bus_lvl(bus_lvl),
    .p0_sel(p0_e), .p2_sel(p2_e), .p13_sel(p13_e)
  );

  assign mode_o  = mode_q;
  assign p0_sel  = p0_e;
  assign p2_sel  = p2_e;
  assign p13_sel = p13_e;

  // R5/R6: power-down holds the strobes low
  a_r5_pd_bus_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PD) |-> (bus_ovr && !bus_lvl && !port_in_en));

  // R2: idle keeps the peripheral clocks that the mask selects
  a_r2_idle_per_on: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IDLE) |-> (per_clk_en == PER_IDLE_MASK && !cpu_clk_en));

  // R1: run means no overrides and a running CPU
  a_r1_run_clean: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN) |-> (!bus_ovr && cpu_clk_en && p13_sel == 2'd0));
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       irq_pend = 1'b0;
  logic       fetch_valid = 1'b0;
  logic       fetch_ext = 1'b0;
  logic [1:0] mode_o, p0_sel, p2_sel, p13_sel;
  logic       cpu_clk_en, cpu_wr_en, wdt_clk_en, port_in_en, bus_ovr, bus_lvl;
  logic [3:0] per_clk_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .irq_pend(irq_pend), .fetch_valid(fetch_valid), .fetch_ext(fetch_ext),
    .mode_o(mode_o), .cpu_clk_en(cpu_clk_en), .cpu_wr_en(cpu_wr_en),
    .wdt_clk_en(wdt_clk_en), .per_clk_en(per_clk_en), .port_in_en(port_in_en),
    .bus_ovr(bus_ovr), .bus_lvl(bus_lvl), .p0_sel(p0_sel), .p2_sel(p2_sel),
    .p13_sel(p13_sel)
  );

  // {wr, wdata, irq, fetch_valid, fetch_ext, exp_mode, exp_p0, exp_p2}
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 2'd1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 2'd2},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3, 2'd2},
    {1'b1, 8'h82, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 2'd2},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 2'd2},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h80, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 8'h02, 1'b0, 1'b1, 1'b1, 2'd2, 2'd3, 2'd1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd2, 2'd3, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic wr, input logic [7:0] wd, input logic irq,
                      input logic fv, input logic fx);
    reg_wr = wr; reg_wdata = wd; irq_pend = irq; fetch_valid = fv; fetch_ext = fx;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; irq_pend = 1'b0; fetch_valid = 1'b0; fetch_ext = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // table walk: R2 R3 R4 R7 R8 R10 R11
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][17], VEC[v][16:9], VEC[v][8], VEC[v][7], VEC[v][6]);
      chk($sformatf("R2/R3/R4/R7/R8/R10/R11 vec%0d mode", v), 32'(mode_o), 32'(VEC[v][5:4]));
      chk($sformatf("R7/R8/R10 vec%0d p0", v), 32'(p0_sel), 32'(VEC[v][3:2]));
      chk($sformatf("R7/R8/R10 vec%0d p2", v), 32'(p2_sel), 32'(VEC[v][1:0]));
    end
    chk("R5 irq ignored in power-down", 32'(mode_o), 32'd2);

    // R1: reset leaves power-down and restores every output
    do_reset();
    chk("R1 mode", 32'(mode_o), 32'd0);
    chk("R1 clocks", {28'd0, cpu_clk_en, cpu_wr_en, wdt_clk_en, port_in_en}, 32'hf);
    chk("R1 per_clk_en", 32'(per_clk_en), 32'hf);
    chk("R1 selects", {25'd0, bus_ovr, p0_sel, p2_sel, p13_sel}, 32'd0);

    // R3: interrupt in run has no effect
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R3 irq in run", 32'(mode_o), 32'd0);

    // R2/R6/R7/R9: idle with internal fetch
    step(1'b1, 8'h01, 1'b0, 1'b1, 1'b0);
    chk("R2 idle mode", 32'(mode_o), 32'd1);
    chk("R2 idle cpu/wr/wdt", {29'd0, cpu_clk_en, cpu_wr_en, wdt_clk_en}, 32'd0);
    chk("R2 idle per_clk_en", 32'(per_clk_en), 32'hf);
    chk("R2 idle port_in_en", 32'(port_in_en), 32'd1);
    chk("R6 idle strobes high", {30'd0, bus_ovr, bus_lvl}, 32'd3);
    chk("R9 idle ports 1/3", 32'(p13_sel), 32'd0);
    chk("R7 idle p0/p2 latch", {28'd0, p0_sel, p2_sel}, 32'h5);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R3 wake to run", 32'(mode_o), 32'd0);

    // R4: intervening write disarms
    step(1'b1, 8'h80, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    chk("R4 disarmed by other write", 32'(mode_o), 32'd0);
    // R4: combined arm+pd write only arms
    step(1'b1, 8'h82, 1'b0, 1'b0, 1'b0);
    chk("R4 combined write stays run", 32'(mode_o), 32'd0);
    step(1'b1, 8'h03, 1'b0, 1'b0, 1'b0);
    chk("R4 armed write enters pd over idle", 32'(mode_o), 32'd2);

    // R5/R6/R7/R9: power-down outputs, internal origin
    chk("R5 pd clocks", {28'd0, cpu_clk_en, cpu_wr_en, wdt_clk_en, port_in_en}, 32'd0);
    chk("R5 pd per_clk_en", 32'(per_clk_en), 32'd0);
    chk("R6 pd strobes low", {30'd0, bus_ovr, bus_lvl}, 32'd2);
    chk("R9 pd ports 1/3 hold", 32'(p13_sel), 32'd1);
    chk("R7 pd p0/p2 latch", {28'd0, p0_sel, p2_sel}, 32'h5);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 pd ignores irq", 32'(mode_o), 32'd2);
    do_reset();
    chk("R1 reset exits pd", 32'(mode_o), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule